// File: doc/BRIEF.md
# Window Compare Fault Pulse Generator

This block watches a stream of converted sample values and tests each valid sample against a programmable window defined by a low and a high threshold. When the selected compare condition is met, it raises a fault pulse that lasts exactly one clock cycle. Separately, it sets a sticky compare status bit that software clears with a read strobe. The pulse and the status bit do not depend on each other.

The pulse drives a fault stage that sits in front of a bank of PWM outputs. When the fault input of that stage is enabled, a pulse forces every PWM output to its safe level in the same cycle, through combinational logic only. The stage also latches the fault, so the outputs stay safe after the one-cycle pulse has ended. Only an explicit clear strobe releases the latch. With the fault input disabled, the PWM outputs pass through unchanged.

Top module: `window_fault_guard`

## Requirements
- R1: `cmp_mode` selects the condition: 0 = sample < `thr_lo`, 1 = sample > `thr_hi`, 2 = `thr_lo` <= sample <= `thr_hi`, 3 = sample < `thr_lo` or sample > `thr_hi`. Both thresholds are unsigned, and a sample equal to a threshold counts as inside.
- R2: A sample is compared only in a cycle where `smp_valid` is high. A matching value with `smp_valid` low produces no pulse and no status change.
- R3: A matching valid sample captured at a clock edge makes `fault_pulse` high for exactly the one cycle after that edge. It is low in the following cycle unless another matching sample was captured.
- R4: `cmp_status` sets on the same edge that raises `fault_pulse` and holds. It clears on the edge where `status_rd` is high, unless a new compare event arrives on that edge, in which case it stays set.
- R5: `fault_pulse` does not depend on `cmp_status`. A pulse is produced even when the status is already set, and a `status_rd` in the cycle of a pulse leaves the pulse unchanged.
- R6: While `flt_en` is low, `pwm_out` equals `pwm_in`, and a pulse does not set `fault_held`.
- R7: While `flt_en` is high and `fault_pulse` is high, `pwm_out` equals `SAFE_LEVEL` in that same cycle.
- R8: A pulse that arrives while `flt_en` is high sets `fault_held` on the next edge. While `fault_held` and `flt_en` are both high, `pwm_out` stays at `SAFE_LEVEL`. `flt_clr` clears `fault_held` on the next edge.
- R9: A `flt_clr` sampled on an edge where `fault_pulse` is high is ignored, and `fault_held` stays set.
- R10: After reset, `fault_pulse`, `cmp_status` and `fault_held` are low and `pwm_out` equals `pwm_in`.
- R11: With no pulse and no held fault, `pwm_out` follows `pwm_in` combinationally for any input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DW | Converted sample value |
| thr_lo | input | DW | Low threshold |
| thr_hi | input | DW | High threshold |
| cmp_mode | input | 2 | Compare condition select |
| status_rd | input | 1 | Status read/clear strobe |
| flt_en | input | 1 | Fault input enable on the PWM side |
| flt_clr | input | 1 | Clear strobe for the held fault |
| pwm_in | input | NCH | Raw PWM outputs |
| fault_pulse | output | 1 | One-cycle fault pulse |
| cmp_status | output | 1 | Sticky compare status |
| fault_held | output | 1 | Latched fault on the PWM side |
| pwm_out | output | NCH | Safe-gated PWM outputs |

## Verification
A comparator that decodes the wrong mode or gets a boundary wrong shows up one cycle after the offending sample, as a missing or extra `fault_pulse`. A wrong status register shows up on `cmp_status` on that same edge. Corruption in the held-fault latch shows up on `pwm_out` from the cycle after the pulse onward, and persists until the clear strobe. A gating fault shows up on `pwm_out` at once, within the cycle the pulse is high.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
   typedef enum logic [1:0] {
      CMP_BELOW   = 2'd0,
      CMP_ABOVE   = 2'd1,
      CMP_INSIDE  = 2'd2,
      CMP_OUTSIDE = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/wcf_window_cmp.sv
module wcf_window_cmp #(
   parameter int DW = 12
) (
   input  logic          valid,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic [1:0]    mode,
   output logic          hit
);
   import wcf_pkg::*;

   logic below_lo;
   logic above_hi;
   logic cond;

   assign below_lo = data < lo;
   assign above_hi = data > hi;

   always_comb begin
      unique case (cmp_mode_e'(mode))
         CMP_BELOW:   cond = below_lo;
         CMP_ABOVE:   cond = above_hi;
         CMP_INSIDE:  cond = !below_lo && !above_hi;
         CMP_OUTSIDE: cond = below_lo || above_hi;
         default:     cond = 1'b0;
      endcase
   end

   assign hit = valid && cond;
endmodule

// File: rtl/wcf_event_regs.sv
module wcf_event_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic status_rd,
   output logic pulse,
   output logic status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse  <= 1'b0;
         status <= 1'b0;
      end else begin
         pulse <= hit;
         if (hit)
            status <= 1'b1;
         else if (status_rd)
            status <= 1'b0;
      end
   end
endmodule

// File: rtl/wcf_safe_gate.sv
module wcf_safe_gate #(
   parameter int             NCH        = 6,
   parameter logic [NCH-1:0] SAFE_LEVEL = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pulse,
   input  logic           en,
   input  logic           clr,
   input  logic [NCH-1:0] pwm_in,
   output logic           held,
   output logic [NCH-1:0] pwm_out
);
   logic force_safe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= 1'b0;
      else if (en && pulse)
         held <= 1'b1;
      else if (clr && !pulse)
         held <= 1'b0;
   end

   assign force_safe = en && (pulse || held);

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      assign pwm_out[ch] = force_safe ? SAFE_LEVEL[ch] : pwm_in[ch];
   end
endmodule

// File: rtl/window_fault_guard.sv
module window_fault_guard #(
   parameter int             DW         = 12,
   parameter int             NCH        = 6,
   parameter logic [NCH-1:0] SAFE_LEVEL = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   input  logic [DW-1:0]  smp_data,
   input  logic [DW-1:0]  thr_lo,
   input  logic [DW-1:0]  thr_hi,
   input  logic [1:0]     cmp_mode,
   input  logic           status_rd,
   input  logic           flt_en,
   input  logic           flt_clr,
   input  logic [NCH-1:0] pwm_in,
   output logic           fault_pulse,
   output logic           cmp_status,
   output logic           fault_held,
   output logic [NCH-1:0] pwm_out
);
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("window_fault_guard: DW out of range");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("window_fault_guard: NCH must be positive");
   end

   logic hit;

   wcf_window_cmp #(.DW(DW)) u_cmp (
      .valid (smp_valid),
      .data  (smp_data),
      .lo    (thr_lo),
      .hi    (thr_hi),
      .mode  (cmp_mode),
      .hit   (hit)
   );

   wcf_event_regs u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .status_rd (status_rd),
      .pulse     (fault_pulse),
      .status    (cmp_status)
   );

   wcf_safe_gate #(.NCH(NCH), .SAFE_LEVEL(SAFE_LEVEL)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse   (fault_pulse),
      .en      (flt_en),
      .clr     (flt_clr),
      .pwm_in  (pwm_in),
      .held    (fault_held),
      .pwm_out (pwm_out)
   );
endmodule

// File: rtl/wfg_checker.sv
module wfg_checker #(
   parameter int             NCH        = 6,
   parameter logic [NCH-1:0] SAFE_LEVEL = '0
) (
   input logic           clk,
   input logic           rst_n,
   input logic           smp_valid,
   input logic           status_rd,
   input logic           flt_en,
   input logic [NCH-1:0] pwm_in,
   input logic           fault_pulse,
   input logic           cmp_status,
   input logic           fault_held,
   input logic [NCH-1:0] pwm_out
);
   // R2
   pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> $past(smp_valid));

   // R4
   status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_status) |-> fault_pulse);

   // R4
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_status && !fault_pulse) |-> ($past(cmp_status) && !$past(status_rd)));

   // R6
   bypass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_en |-> (pwm_out == pwm_in));

   // R7
   safe_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en && fault_pulse) |-> (pwm_out == SAFE_LEVEL));

   // R8
   held_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en && fault_pulse) |=> fault_held);

   // R8
   held_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_held) |-> $past(flt_en && fault_pulse));
endmodule

bind window_fault_guard wfg_checker #(.NCH(NCH), .SAFE_LEVEL(SAFE_LEVEL)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .status_rd   (status_rd),
   .flt_en      (flt_en),
   .pwm_in      (pwm_in),
   .fault_pulse (fault_pulse),
   .cmp_status  (cmp_status),
   .fault_held  (fault_held),
   .pwm_out     (pwm_out)
);

// File: tb/window_fault_guard_tb_top.sv
module window_fault_guard_tb_top;
   localparam int        DW   = 12;
   localparam int        NCH  = 6;
   localparam logic [5:0] SAFE = 6'b101010;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           smp_valid = 1'b0;
   logic [DW-1:0]  smp_data = '0;
   logic [DW-1:0]  thr_lo = 12'd100;
   logic [DW-1:0]  thr_hi = 12'd200;
   logic [1:0]     cmp_mode = 2'd0;
   logic           status_rd = 1'b0;
   logic           flt_en = 1'b0;
   logic           flt_clr = 1'b0;
   logic [NCH-1:0] pwm_in = 6'b010011;
   logic           fault_pulse, cmp_status, fault_held;
   logic [NCH-1:0] pwm_out;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   window_fault_guard #(.DW(DW), .NCH(NCH), .SAFE_LEVEL(SAFE)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .thr_lo(thr_lo), .thr_hi(thr_hi), .cmp_mode(cmp_mode),
      .status_rd(status_rd), .flt_en(flt_en), .flt_clr(flt_clr),
      .pwm_in(pwm_in), .fault_pulse(fault_pulse), .cmp_status(cmp_status),
      .fault_held(fault_held), .pwm_out(pwm_out)
   );

   typedef struct {
      logic       p;
      logic       s;
      logic       h;
      logic [5:0] pw;
      string      tag;
   } exp_t;

   exp_t q[$];

   logic m_p = 1'b0, m_s = 1'b0, m_h = 1'b0;

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   function automatic logic model_hit(logic v, logic [11:0] d, logic [1:0] m);
      logic lo_m, hi_m;
      lo_m = d < thr_lo;
      hi_m = d > thr_hi;
      case (m)
         2'd0: return v && lo_m;
         2'd1: return v && hi_m;
         2'd2: return v && !lo_m && !hi_m;
         default: return v && (lo_m || hi_m);
      endcase
   endfunction

   // driver: one cycle of stimulus, expected post-edge values pushed to scoreboard
   task automatic cyc(input logic v, input logic [11:0] d, input logic [1:0] m,
                      input logic rd, input logic en, input logic clr,
                      input logic [5:0] pw, input string tag);
      exp_t e;
      logic hit, np, ns, nh;
      @(negedge clk);
      smp_valid = v; smp_data = d; cmp_mode = m;
      status_rd = rd; flt_en = en; flt_clr = clr; pwm_in = pw;
      hit = model_hit(v, d, m);
      np = hit;
      ns = hit ? 1'b1 : (rd ? 1'b0 : m_s);
      nh = (en && m_p) ? 1'b1 : ((clr && !m_p) ? 1'b0 : m_h);
      m_p = np; m_s = ns; m_h = nh;
      e.p = np; e.s = ns; e.h = nh;
      e.pw = (en && (np || nh)) ? SAFE : pw;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, {5'd0, fault_pulse}, {5'd0, e.p}, "fault_pulse");
            chk(e.tag, {5'd0, cmp_status}, {5'd0, e.s}, "cmp_status");
            chk(e.tag, {5'd0, fault_held}, {5'd0, e.h}, "fault_held");
            chk(e.tag, pwm_out, e.pw, "pwm_out");
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk("R10", {3'd0, fault_pulse, cmp_status, fault_held}, 6'd0, "flags");
      chk("R10", pwm_out, pwm_in, "pwm_out");
      @(negedge clk);
      rst_n = 1'b1;

      // R11 pass-through with enable on and no fault
      cyc(0, 12'd0, 2'd0, 0, 1, 0, 6'b111000, "R11");
      cyc(0, 12'd0, 2'd0, 0, 1, 0, 6'b000111, "R11");
      // R1 below mode, boundary 99 hits, then R3 single-cycle pulse, R8 hold
      cyc(1, 12'd99, 2'd0, 0, 1, 0, 6'b110011, "R1_below");
      cyc(0, 12'd0, 2'd0, 0, 1, 0, 6'b110011, "R3_pulse");
      cyc(0, 12'd0, 2'd0, 0, 1, 0, 6'b001100, "R8_hold");
      cyc(0, 12'd0, 2'd0, 0, 1, 1, 6'b001100, "R8_clr");
      cyc(0, 12'd0, 2'd0, 1, 1, 0, 6'b001101, "R4_rdclr");
      cyc(1, 12'd100, 2'd0, 0, 1, 0, 6'b001101, "R1_below_edge");
      // R1 above
      cyc(1, 12'd200, 2'd1, 0, 0, 0, 6'b000001, "R1_above_edge");
      cyc(1, 12'd201, 2'd1, 0, 0, 0, 6'b000001, "R1_above");
      cyc(0, 12'd0, 2'd1, 1, 0, 0, 6'b000011, "R6_off");
      // R1 inside
      cyc(1, 12'd100, 2'd2, 0, 0, 0, 6'b000011, "R1_inside_lo");
      cyc(1, 12'd200, 2'd2, 0, 0, 0, 6'b000011, "R1_inside_hi");
      cyc(1, 12'd201, 2'd2, 0, 0, 0, 6'b000011, "R1_inside_out");
      // R1 outside
      cyc(1, 12'd150, 2'd3, 1, 0, 0, 6'b000111, "R1_outside_in");
      cyc(1, 12'd99, 2'd3, 0, 0, 0, 6'b000111, "R1_outside");
      cyc(1, 12'd4095, 2'd3, 0, 0, 0, 6'b000111, "R1_outside_hi");
      cyc(0, 12'd0, 2'd3, 1, 0, 0, 6'b000111, "R4_rdclr");
      // R2 valid low ignored
      cyc(0, 12'd5, 2'd0, 0, 1, 0, 6'b011110, "R2_invalid");
      cyc(0, 12'd5, 2'd0, 0, 1, 0, 6'b011110, "R2_invalid");
      // R4 read with simultaneous event keeps status; R5 pulse independent of status
      cyc(1, 12'd10, 2'd0, 0, 0, 0, 6'b100001, "R4_set");
      cyc(1, 12'd10, 2'd0, 1, 0, 0, 6'b100001, "R5_rd_with_event");
      cyc(0, 12'd0, 2'd0, 0, 0, 0, 6'b100001, "R5_status_kept");
      cyc(1, 12'd10, 2'd0, 0, 0, 0, 6'b100001, "R5_pulse_status_set");
      cyc(0, 12'd0, 2'd0, 1, 0, 0, 6'b100001, "R5_rd_during_pulse");
      // R6 disabled fault input does not latch
      cyc(1, 12'd300, 2'd1, 0, 0, 0, 6'b111111, "R6_off");
      cyc(0, 12'd0, 2'd1, 0, 0, 0, 6'b111111, "R6_nolatch");
      // R7 same-cycle safe, R9 clear ignored while pulse
      cyc(1, 12'd300, 2'd1, 0, 1, 0, 6'b111111, "R7_safe");
      cyc(0, 12'd0, 2'd1, 0, 1, 1, 6'b010101, "R9_clr_ignored");
      cyc(0, 12'd0, 2'd1, 0, 1, 0, 6'b010101, "R9_still_held");
      cyc(0, 12'd0, 2'd1, 0, 0, 0, 6'b010101, "R8_en_off_bypass");
      cyc(0, 12'd0, 2'd1, 0, 1, 1, 6'b010101, "R8_clr");
      cyc(0, 12'd0, 2'd1, 0, 1, 0, 6'b110110, "R11");
      cyc(0, 12'd0, 2'd1, 0, 1, 0, 6'b110110, "R11");
      repeat (3) @(posedge clk);
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule